// File: doc/BRIEF.md
# UART Receive Status Byte Packer

This block sits between a UART character receiver and a byte-wide receive FIFO. Each time the receiver presents a finished character, together with its parity-error, framing-error, break and overrun flags, the packer turns it into FIFO writes. In normal mode it writes one data byte per character. In wide mode it writes the data byte and then a status byte that carries that character's own error flags, so software reading the FIFO can tell exactly which character was damaged.

Character lengths of 7, 8 and 9 bits are supported. In 9-bit wide mode the ninth data bit takes over the status bit that otherwise carries the parity error, because parity is not used with 9-bit characters. The mode and length settings are captured when a character arrives, so a pair that is already queued is always finished in the layout it started with. The FIFO side is a valid/ready write port. A character that arrives while the packer cannot take it is dropped, and the loss is reported as an overrun on the next character that is accepted.

Top module: `rxpk_top`

## Requirements
- R1: In normal mode (`cfg_wide`=0) each accepted character produces exactly one FIFO write, and its byte is character bits 7..0, including in 9-bit mode.
- R2: In wide mode (`cfg_wide`=1) each accepted character produces exactly two FIFO writes on consecutive accepted transfers: the data byte first, then the status byte.
- R3: Status byte layout: bit 0 = parity error, bit 1 = break, bit 2 = framing error, bit 3 = overrun, bits 7..4 = 0.
- R4: For 7- and 8-bit characters, status bit 0 is 0 whenever `cfg_par_en` is 0, whatever `chr_par_err` is.
- R5: `cfg_len` encoding: 0 = 7-bit, 1 = 8-bit, 2 = 9-bit, 3 = 8-bit. In 7-bit mode bit 7 of the data byte is always written as 0.
- R6: In 9-bit wide mode status bit 0 holds character bit 8, `chr_par_err` has no effect, and break, framing and overrun keep bits 1, 2 and 3.
- R7: While `fifo_wr` is high and `fifo_rdy` is low, `fifo_wr` stays high and `fifo_data` holds its value; a wide pair is never split or partly dropped.
- R8: A character strobed while the packer cannot accept it is dropped without any FIFO write, and status bit 3 is set in the status of the next accepted character.
- R9: Mode and length are taken from the cycle the character is accepted; changing them later does not alter bytes already queued.
- R10: After reset no FIFO write is pending, even if `chr_vld` was high during reset.
- R11: With `fifo_rdy` held high, a strobe on `chr_vld` in one cycle leads to `fifo_wr` high in the next, and normal mode accepts one character every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_vld | input | 1 | One-cycle strobe: a received character is present |
| chr_bits | input | 9 | Received character bits, bit 0 first received |
| chr_par_err | input | 1 | Parity error for this character |
| chr_frm_err | input | 1 | Framing error for this character |
| chr_brk | input | 1 | Break detected with this character |
| chr_ovr | input | 1 | Receiver overrun flagged with this character |
| cfg_wide | input | 1 | 1 = write data and status bytes, 0 = data byte only |
| cfg_len | input | 2 | Character length select (see R5) |
| cfg_par_en | input | 1 | Parity checking enabled |
| fifo_rdy | input | 1 | FIFO can accept a byte this cycle |
| fifo_wr | output | 1 | Byte valid toward the FIFO |
| fifo_data | output | 8 | Byte toward the FIFO |

## Verification
A wrong internal count of queued bytes shows at the ports within one or two cycles: either a status byte is missing after a wide data byte, or a stray extra write appears after a normal one, and the bench checks for idle after every character. A wrong shift of the queued status byte, or a lost overrun marker, shows on the very next status byte written. Holding behaviour under a stalled FIFO is checked across several stalled cycles, with a configuration change and a dropped character placed in the middle of the stall.

// File: rtl/rxpk_pkg.sv
`timescale 1ns/1ps
package rxpk_pkg;

    localparam int BYTE_W = 8;
    localparam int CHR_W  = 9;
    localparam int LEN_W  = 2;

    // Status byte bit positions (decoded by software reading the FIFO)
    localparam int ST_PAR_OR_D8 = 0;
    localparam int ST_BRK       = 1;
    localparam int ST_FRM       = 2;
    localparam int ST_OVR       = 3;

    typedef enum logic [LEN_W-1:0] {
        LEN_7  = 2'd0,
        LEN_8  = 2'd1,
        LEN_9  = 2'd2,
        LEN_8B = 2'd3
    } len_e;

    typedef struct packed {
        logic [CHR_W-1:0] bits;
        logic             par_err;
        logic             frm_err;
        logic             brk;
        logic             ovr;
    } chr_t;

    typedef struct packed {
        logic wide;
        len_e len;
        logic par_en;
    } cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] stat;
        logic              two;
    } pair_t;

    function automatic logic [BYTE_W-1:0] make_data(input chr_t c, input cfg_t g);
        logic [BYTE_W-1:0] d;
        d = c.bits[BYTE_W-1:0];
        if (g.len == LEN_7) begin
            d[BYTE_W-1] = 1'b0;
        end
        return d;
    endfunction

    function automatic logic [BYTE_W-1:0] make_stat(input chr_t c, input cfg_t g,
                                                    input logic lost);
        logic [BYTE_W-1:0] s;
        s = '0;
        if (g.len == LEN_9) begin
            s[ST_PAR_OR_D8] = c.bits[CHR_W-1];
        end else begin
            s[ST_PAR_OR_D8] = c.par_err & g.par_en;
        end
        s[ST_BRK] = c.brk;
        s[ST_FRM] = c.frm_err;
        s[ST_OVR] = c.ovr | lost;
        return s;
    endfunction

endpackage

// File: rtl/rxpk_format.sv
`timescale 1ns/1ps
module rxpk_format
    import rxpk_pkg::*;
(
    input  chr_t  chr,
    input  cfg_t  cfg,
    input  logic  lost,
    output pair_t pair
);
    always_comb begin
        pair.data = make_data(chr, cfg);
        pair.stat = make_stat(chr, cfg, lost);
        pair.two  = cfg.wide;
    end
endmodule

// File: rtl/rxpk_lost.sv
`timescale 1ns/1ps
module rxpk_lost (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic take,
    output logic lost
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lost <= 1'b0;
        end else if (drop) begin
            lost <= 1'b1;
        end else if (take) begin
            lost <= 1'b0;
        end
    end

    AST_DROP_MARKS: assert property (@(posedge clk) disable iff (rst)
        drop |=> lost) else $error("drop not remembered"); // R8
endmodule

// File: rtl/rxpk_emit.sv
`timescale 1ns/1ps
module rxpk_emit
    import rxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  pair_t             pair,
    input  logic              fifo_rdy,
    output logic              can_take,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data
);
    localparam int CNT_W = 2;

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] head_q;
    logic [BYTE_W-1:0] tail_q;
    logic              pop;

    assign fifo_wr   = (cnt_q != '0);
    assign fifo_data = head_q;
    assign pop       = fifo_wr & fifo_rdy;
    assign can_take  = (cnt_q == 2'd0) | ((cnt_q == 2'd1) & fifo_rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else if (take) begin
            head_q <= pair.data;
            tail_q <= pair.stat;
            cnt_q  <= pair.two ? 2'd2 : 2'd1;
        end else if (pop) begin
            cnt_q <= cnt_q - 2'd1;
            if (cnt_q == 2'd2) begin
                head_q <= tail_q;
            end
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !fifo_rdy) |=> (fifo_wr && $stable(fifo_data))) else $error("stall broke"); // R7
    AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == 2'd2 && fifo_rdy) |=> fifo_wr) else $error("status missing"); // R2
    AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == 2'd2 && fifo_rdy) |=> (fifo_data[BYTE_W-1:4] == '0)) else $error("status upper"); // R3
endmodule

// File: rtl/rxpk_top.sv
`timescale 1ns/1ps
module rxpk_top
    import rxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chr_vld,
    input  logic [CHR_W-1:0]  chr_bits,
    input  logic              chr_par_err,
    input  logic              chr_frm_err,
    input  logic              chr_brk,
    input  logic              chr_ovr,
    input  logic              cfg_wide,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              fifo_rdy,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data
);
    chr_t  chr;
    cfg_t  cfg;
    pair_t pair;
    logic  can_take;
    logic  take;
    logic  drop;
    logic  lost;

    always_comb begin
        chr.bits    = chr_bits;
        chr.par_err = chr_par_err;
        chr.frm_err = chr_frm_err;
        chr.brk     = chr_brk;
        chr.ovr     = chr_ovr;
        cfg.wide    = cfg_wide;
        cfg.len     = len_e'(cfg_len);
        cfg.par_en  = cfg_par_en;
    end

    assign take = chr_vld & can_take;
    assign drop = chr_vld & ~can_take;

    rxpk_format u_format (
        .chr  (chr),
        .cfg  (cfg),
        .lost (lost),
        .pair (pair)
    );

    rxpk_lost u_lost (
        .clk  (clk),
        .rst  (rst),
        .drop (drop),
        .take (take),
        .lost (lost)
    );

    rxpk_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .pair      (pair),
        .fifo_rdy  (fifo_rdy),
        .can_take  (can_take),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data)
    );

    AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (chr_vld && fifo_rdy && !(fifo_wr && fifo_data != fifo_data)) && can_take |=> fifo_wr) else $error("no write"); // R11
    AST_LEN7_MSB: assert property (@(posedge clk) disable iff (rst)
        (take && cfg_len == LEN_7) |=> (fifo_data[BYTE_W-1] == 1'b0)) else $error("bit7 set"); // R5
endmodule

// File: tb/rxpk_top_bench.sv
`timescale 1ns/1ps
module rxpk_top_bench;

    typedef struct packed {
        logic       wide;
        logic [1:0] len;
        logic       pe;
        logic [8:0] bits;
        logic       par;
        logic       frm;
        logic       brk;
        logic       ovr;
        logic [7:0] ed;
        logic [7:0] es;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 1'b1, 9'h0A5, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h00}, // R1 normal 8-bit
        '{1'b0, 2'd0, 1'b1, 9'h0F3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h73, 8'h00}, // R5 normal 7-bit
        '{1'b0, 2'd2, 1'b0, 9'h1C4, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC4, 8'h00}, // R1 normal 9-bit
        '{1'b1, 2'd1, 1'b1, 9'h03C, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h01}, // R3 parity
        '{1'b1, 2'd1, 1'b0, 9'h0C3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h04}, // R4 parity off
        '{1'b1, 2'd0, 1'b1, 9'h0FF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h7F, 8'h03}, // R5 R3
        '{1'b1, 2'd1, 1'b1, 9'h000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h08}, // R3 overrun
        '{1'b1, 2'd2, 1'b1, 9'h15A, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h05}, // R6 bit8=1
        '{1'b1, 2'd2, 1'b1, 9'h081, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h02}, // R6 bit8=0
        '{1'b1, 2'd3, 1'b0, 9'h1EE, 1'b1, 1'b1, 1'b1, 1'b1, 8'hEE, 8'h0E}  // R5 code 3
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chr_vld = 1'b0;
    logic [8:0] chr_bits = '0;
    logic       chr_par_err = 1'b0;
    logic       chr_frm_err = 1'b0;
    logic       chr_brk = 1'b0;
    logic       chr_ovr = 1'b0;
    logic       cfg_wide = 1'b0;
    logic [1:0] cfg_len = 2'd1;
    logic       cfg_par_en = 1'b0;
    logic       fifo_rdy = 1'b1;
    logic       fifo_wr;
    logic [7:0] fifo_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxpk_top u_rxpk_top (
        .clk         (clk),
        .rst         (rst),
        .chr_vld     (chr_vld),
        .chr_bits    (chr_bits),
        .chr_par_err (chr_par_err),
        .chr_frm_err (chr_frm_err),
        .chr_brk     (chr_brk),
        .chr_ovr     (chr_ovr),
        .cfg_wide    (cfg_wide),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .fifo_rdy    (fifo_rdy),
        .fifo_wr     (fifo_wr),
        .fifo_data   (fifo_data)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input string req, input logic [7:0] b);
        check(req, {fifo_wr, fifo_data}, {1'b1, b});
    endtask

    task automatic expect_idle(input string req);
        check(req, {fifo_wr, 8'h00}, 9'h000);
    endtask

    // Called at a negedge: drives one strobe, returns at the next negedge.
    task automatic strobe(input logic [8:0] bits, input logic par, input logic frm,
                          input logic brk, input logic ovr);
        chr_bits    = bits;
        chr_par_err = par;
        chr_frm_err = frm;
        chr_brk     = brk;
        chr_ovr     = ovr;
        chr_vld     = 1'b1;
        @(negedge clk);
        chr_vld     = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: strobe held during reset must leave nothing queued
        chr_vld  = 1'b1;
        chr_bits = 9'h055;
        repeat (3) @(negedge clk);
        rst     = 1'b0;
        chr_vld = 1'b0;
        @(negedge clk);
        expect_idle("R10 after reset");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            cfg_wide   = VECS[i].wide;
            cfg_len    = VECS[i].len;
            cfg_par_en = VECS[i].pe;
            strobe(VECS[i].bits, VECS[i].par, VECS[i].frm, VECS[i].brk, VECS[i].ovr);
            expect_byte("R11/R1/R5 data byte", VECS[i].ed);
            @(negedge clk);
            if (VECS[i].wide) begin
                expect_byte("R2/R3/R4/R6 status byte", VECS[i].es);
                @(negedge clk);
            end
            expect_idle("R1/R2 no extra write");
        end

        // R11: back-to-back normal characters
        cfg_wide = 1'b0;
        cfg_len  = 2'd1;
        strobe(9'h011, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_byte("R11 first", 8'h11);
        strobe(9'h022, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_byte("R11 second", 8'h22);
        strobe(9'h033, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_byte("R11 third", 8'h33);
        @(negedge clk);
        expect_idle("R11 drained");

        // R7/R8/R9: stall, drop, config change
        cfg_wide = 1'b1;
        fifo_rdy = 1'b0;
        strobe(9'h05A, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_byte("R7 stalled data", 8'h5A);
        @(negedge clk);
        @(negedge clk);
        expect_byte("R7 held data", 8'h5A);
        strobe(9'h077, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_byte("R8 drop leaves head", 8'h5A);
        cfg_wide = 1'b0;
        cfg_len  = 2'd0;
        fifo_rdy = 1'b1;
        @(negedge clk);
        expect_byte("R9 status kept after cfg change", 8'h04);
        @(negedge clk);
        expect_idle("R8 dropped char never written");
        cfg_wide = 1'b1;
        cfg_len  = 2'd1;
        strobe(9'h012, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_byte("R8 next data", 8'h12);
        @(negedge clk);
        expect_byte("R8 overrun on next status", 8'h08);
        @(negedge clk);
        expect_idle("R8 idle");
        strobe(9'h034, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        expect_byte("R8 overrun cleared", 8'h00);
        @(negedge clk);

        // R7: stall while the status byte is at the head
        strobe(9'h0AB, 1'b1, 1'b0, 1'b1, 1'b0);
        cfg_par_en = 1'b0;
        fifo_rdy   = 1'b0;
        expect_byte("R7 data before stall", 8'hAB);
        @(negedge clk);
        expect_byte("R7 data still held", 8'hAB);
        fifo_rdy = 1'b1;
        @(negedge clk);
        fifo_rdy = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_byte("R7 status held", 8'h02);
        fifo_rdy = 1'b1;
        @(negedge clk);
        expect_idle("R7 pair complete");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule